// File: doc/BRIEF.md
# Shared-Period Pad Debounce Filter Bank

This block cleans up slow or noisy pad inputs for a group of pads that draw their filter timing from six shared period slots. Each pad carries a 3-bit slot select. A slot holds a 6-bit code that expands into a number of debounce-clock cycles. A pad's clean output moves to a new level only after its synchronized input has stayed at that level for that many cycles in a row. A code of zero, a select outside 1..6, or a pad that the build-time mask marks as unable to filter all give a pass-through path. That path has the same latency as a one-cycle filter.

The clock that drives the filter can come from a selector that does not switch cleanly. For this reason, configuration is only taken while the enable input is low. Slot writes and pad selects are captured only in that state. The clean outputs are held at zero until the enable rises. On the first enabled edge, each output loads the current synchronized pad level without counting.

Each pad filter is a three-state machine. OFF is the state while the enable is low; the output is zero and the counter is clear. OFF moves to HOLD on the first enabled edge and loads the output. In HOLD, a difference between the input and the output either copies the input at once (pass-through, or a period of one) or starts the count and moves to COUNT. COUNT returns to HOLD when the input falls back to the output level, which is a rejected glitch. It also returns to HOLD when the count reaches the period, which is an accepted change. Any cycle with the enable low forces OFF.

Top module: `pad_debounce_bank`

## Requirements
- R1: Pad select values 1 to 6 pick the slot of the same number. Select values 0 and 7 give pass-through for that pad.
- R2: A slot code of 0 gives pass-through for every pad that selects the slot.
- R3: Codes 1 to 21 require (code + 1) × 32 stable cycles, so code 1 needs 64 and code 21 needs 704.
- R4: Codes 22 to 31 require (code − 21) × 512 stable cycles, so code 22 needs 512 and code 31 needs 5120.
- R5: Codes 32 to 53 require (code − 31) stable cycles, so code 32 needs 1 and code 53 needs 22.
- R6: Codes 54 to 63 require (code − 53) × 512 stable cycles, so code 54 needs 512 and code 63 needs 5120.
- R7: Let P be the required cycle count. A new pad level is taken only if the raw input holds it for at least P consecutive clock edges. The output changes on the (P+1)-th rising edge after the first edge that samples the new raw level. Pass-through behaves as P = 1.
- R8: While the enable is low, every clean output is 0. On the first rising edge with the enable high, each output takes the synchronized pad level, whatever the period.
- R9: Slot writes (wr_en, 1-based slot number on wr_sel; values 0 and 7 ignored) and pad selects take effect only while the enable is low. Changes made while it is high have no effect.
- R10: Pads whose bit in the capability mask is 0 always use pass-through, whatever their select or slot code.
- R11: After reset, all slot codes are 0 and all clean outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debounce clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbnc_en | input | 1 | Filter enable; configuration is accepted only while it is low |
| wr_en | input | 1 | Slot write strobe |
| wr_sel | input | 3 | Slot number to write, 1 to 6 |
| wr_code | input | 6 | Period code to store |
| pad_sel | input | 3*NUM_PADS | Per-pad slot select, pad i in bits [3i+2:3i] |
| pad_raw | input | NUM_PADS | Unfiltered pad levels |
| pad_clean | output | NUM_PADS | Debounced pad levels |

## Verification
The hardest cases to reach from the ports are the exact accept/reject edge of each code range. Code 63 needs a pulse of 5119 cycles to be rejected and one of 5120 cycles to be taken. The table drives raw pulses one cycle short of and exactly at the decoded length for the ends of every range. Proving that configuration is frozen while enabled is also indirect. The bench rewrites a slot and changes a pad select while enabled, then sends a pulse whose outcome would differ under the new setting.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    localparam int CODE_W      = 6;
    localparam int SEL_W       = 3;
    localparam int NUM_PERIODS = 6;
    localparam int CNT_W       = 13;
    localparam int FINE_SHIFT  = 5;
    localparam int COARSE_SHIFT = 9;
    localparam int FINE_LAST   = 21;
    localparam int COARSE1_LAST = 31;
    localparam int UNIT_LAST   = 53;
    localparam int MAX_PERIOD  = 5120;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HOLD,
        ST_COUNT
    } flt_state_e;

    function automatic logic [CNT_W-1:0] decode_period(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] c;
        c = CNT_W'(code);
        if (code == '0)
            return '0;
        else if (c <= CNT_W'(FINE_LAST))
            return (c + CNT_W'(1)) << FINE_SHIFT;
        else if (c <= CNT_W'(COARSE1_LAST))
            return (c - CNT_W'(FINE_LAST)) << COARSE_SHIFT;
        else if (c <= CNT_W'(UNIT_LAST))
            return c - CNT_W'(COARSE1_LAST);
        else
            return (c - CNT_W'(UNIT_LAST)) << COARSE_SHIFT;
    endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end

endmodule

// File: rtl/dbnc_period_regs.sv
module dbnc_period_regs
    import dbnc_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  en,
    input  logic                                  wr_en,
    input  logic [SEL_W-1:0]                      wr_sel,
    input  logic [CODE_W-1:0]                     wr_code,
    output logic [NUM_PERIODS-1:0][CODE_W-1:0]    codes
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            codes <= '0;
        end else if (wr_en && !en) begin
            for (int r = 0; r < NUM_PERIODS; r++) begin
                if (wr_sel == SEL_W'(r + 1))
                    codes[r] <= wr_code;
            end
        end
    end

    // R9: slots never move while the filters run
    p_frozen_when_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(codes));

endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter
    import dbnc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bypass,
    input  logic [CNT_W-1:0] period,
    input  logic             din,
    output logic             dout
);

    flt_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             differs;
    logic             reached;

    assign differs = (din != dout);
    assign reached = ((cnt + CNT_W'(1)) == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (!en) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nxt = ST_HOLD;
                ST_HOLD:  if (differs && !bypass && period > CNT_W'(1)) state_nxt = ST_COUNT;
                ST_COUNT: if (bypass || !differs || reached) state_nxt = ST_HOLD;
                default:  state_nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b0;
            cnt  <= '0;
        end else if (!en) begin
            dout <= 1'b0;
            cnt  <= '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    dout <= din;
                    cnt  <= '0;
                end
                ST_HOLD: begin
                    if (differs) begin
                        if (bypass || period <= CNT_W'(1)) dout <= din;
                        else                               cnt  <= CNT_W'(1);
                    end
                end
                ST_COUNT: begin
                    if (bypass || reached) begin
                        dout <= din;
                        cnt  <= '0;
                    end else if (!differs) begin
                        cnt  <= '0;
                    end else begin
                        cnt  <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    dout <= 1'b0;
                    cnt  <= '0;
                end
            endcase
        end
    end

    // R8: disabled filter drives zero
    p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dout == 1'b0));

    // R8: first enabled edge loads the synchronized level
    p_enable_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (dout == $past(din)));

    // R7: an output change always copies the synchronized input
    p_takes_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && dout != $past(dout)) |-> (dout == $past(din)));

    // R7: count stays within the decoded period
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !bypass) |-> (cnt != '0 && cnt < period));

endmodule

// File: rtl/pad_debounce_bank.sv
module pad_debounce_bank
    import dbnc_pkg::*;
#(
    parameter int                 NUM_PADS  = 4,
    parameter logic [NUM_PADS-1:0] CAP_MASK = 4'b0111
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dbnc_en,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [CODE_W-1:0]         wr_code,
    input  logic [SEL_W*NUM_PADS-1:0] pad_sel,
    input  logic [NUM_PADS-1:0]       pad_raw,
    output logic [NUM_PADS-1:0]       pad_clean
);

    logic [NUM_PERIODS-1:0][CODE_W-1:0] codes;
    logic [NUM_PADS-1:0][SEL_W-1:0]     sel_q;
    logic [NUM_PADS-1:0]                sync_q;

    dbnc_period_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (dbnc_en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_code (wr_code),
        .codes   (codes)
    );

    dbnc_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_raw),
        .d_sync  (sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel_q <= '0;
        else if (!dbnc_en) sel_q <= pad_sel;
    end

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        logic [CODE_W-1:0] code_sel;
        logic [SEL_W-1:0]  slot;
        logic              byp;
        logic [CNT_W-1:0]  per;

        assign slot = sel_q[i] - SEL_W'(1);

        always_comb begin
            code_sel = '0;
            if (sel_q[i] != '0 && sel_q[i] <= SEL_W'(NUM_PERIODS))
                code_sel = codes[slot];
        end

        assign byp = !CAP_MASK[i] || (code_sel == '0);
        assign per = decode_period(code_sel);

        always_comb begin
            if (code_sel != '0)
                p_period_range_r3: assert (per >= CNT_W'(1) && per <= CNT_W'(MAX_PERIOD));
        end

        dbnc_filter u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (dbnc_en),
            .bypass (byp),
            .period (per),
            .din    (sync_q[i]),
            .dout   (pad_clean[i])
        );

        if (!CAP_MASK[i]) begin : g_nocap
            // R10: pads outside the mask track the synchronizer one edge later
            p_nocap_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $past(dbnc_en) |-> (pad_clean[i] == $past(sync_q[i])));
        end
    end

endmodule

// File: tb/tb_pad_debounce_bank.sv
module tb_pad_debounce_bank;

    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dbnc_en;
    logic            wr_en;
    logic [2:0]      wr_sel;
    logic [5:0]      wr_code;
    logic [3*NP-1:0] pad_sel;
    logic [NP-1:0]   pad_raw;
    logic [NP-1:0]   pad_clean;

    int tests = 0;
    int fails = 0;
    int mon_pad = 0;
    bit seen = 1'b0;

    // code, pulse length, expected period
    localparam int NV = 19;
    localparam logic [31:0] VECS [NV] = '{
        {6'd32, 13'd1,    13'd1},
        {6'd33, 13'd1,    13'd2},
        {6'd33, 13'd2,    13'd2},
        {6'd1,  13'd63,   13'd64},
        {6'd1,  13'd64,   13'd64},
        {6'd21, 13'd703,  13'd704},
        {6'd21, 13'd704,  13'd704},
        {6'd22, 13'd511,  13'd512},
        {6'd22, 13'd512,  13'd512},
        {6'd31, 13'd5119, 13'd5120},
        {6'd31, 13'd5120, 13'd5120},
        {6'd53, 13'd21,   13'd22},
        {6'd53, 13'd22,   13'd22},
        {6'd54, 13'd512,  13'd512},
        {6'd63, 13'd5119, 13'd5120},
        {6'd63, 13'd5120, 13'd5120},
        {6'd0,  13'd1,    13'd1},
        {6'd40, 13'd8,    13'd9},
        {6'd40, 13'd9,    13'd9}
    };

    pad_debounce_bank #(.NUM_PADS(NP), .CAP_MASK(4'b0111)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbnc_en   (dbnc_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_code   (wr_code),
        .pad_sel   (pad_sel),
        .pad_raw   (pad_raw),
        .pad_clean (pad_clean)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (pad_clean[mon_pad]) seen = 1'b1;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [5:0] code);
        wr_en = 1'b1; wr_sel = idx; wr_code = code;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int pad, input int len, input int per, output bit hit);
        mon_pad = pad;
        seen = 1'b0;
        pad_raw[pad] = 1'b1;
        cyc(len);
        pad_raw[pad] = 1'b0;
        cyc(per + 6);
        hit = seen;
    endtask

    function automatic string req_of(input logic [5:0] code);
        if (code == 0)       return "R2";
        else if (code <= 21) return "R3";
        else if (code <= 31) return "R4";
        else if (code <= 53) return "R5";
        else                 return "R6";
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit hit;
        rst_n = 1'b0; dbnc_en = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_code = '0;
        pad_sel = {3'd1, 3'd0, 3'd7, 3'd1};
        pad_raw = '0;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        chk(pad_clean, 0, "R11 reset outputs");

        pad_raw = 4'hF;
        cyc(4);
        chk(pad_clean, 0, "R8 disabled holds zero");
        wr(3'd1, 6'd63);
        dbnc_en = 1'b1;
        cyc(1);
        chk(pad_clean, 4'hF, "R8 first enabled edge loads level");
        dbnc_en = 1'b0;
        pad_raw = '0;
        cyc(4);

        for (int v = 0; v < NV; v++) begin
            logic [5:0]  code;
            logic [12:0] len, per;
            {code, len, per} = VECS[v];
            dbnc_en = 1'b0;
            cyc(2);
            wr(3'd1, code);
            dbnc_en = 1'b1;
            cyc(3);
            pulse(0, len, per, hit);
            chk(hit, (len >= per), {req_of(code), " R7 pulse accept"});
        end

        // exact latency, code 35 gives 4 cycles
        dbnc_en = 1'b0; cyc(2); wr(3'd1, 6'd35); dbnc_en = 1'b1; cyc(3);
        pad_raw[0] = 1'b1;
        cyc(5);
        chk(pad_clean[0], 0, "R7 not yet changed");
        cyc(1);
        chk(pad_clean[0], 1, "R7 changes on P+1 edge");
        pad_raw[0] = 1'b0;
        cyc(8);

        // pass-through latency on pads 1 (sel 7), 2 (sel 0), 3 (not capable)
        pad_raw[3:1] = 3'b111;
        cyc(2);
        chk(pad_clean[3:1], 0, "R1 R10 pass-through not yet");
        cyc(1);
        chk(pad_clean[3:1], 3'b111, "R1 R10 pass-through latency");
        pad_raw[3:1] = 3'b000;
        cyc(5);
        pulse(3, 1, 1, hit);
        chk(hit, 1, "R10 masked pad ignores slot code");

        // writes while enabled are ignored
        wr(3'd1, 6'd32);
        pulse(0, 3, 4, hit);
        chk(hit, 0, "R9 enabled write ignored");
        pad_sel[2:0] = 3'd0;
        cyc(2);
        pulse(0, 1, 4, hit);
        chk(hit, 0, "R9 enabled select change ignored");
        pad_sel[2:0] = 3'd1;

        // out-of-range slot numbers ignored
        dbnc_en = 1'b0; cyc(2);
        wr(3'd7, 6'd32); wr(3'd0, 6'd32);
        dbnc_en = 1'b1; cyc(3);
        pulse(0, 3, 4, hit);
        chk(hit, 0, "R9 slot number 0 or 7 ignored");

        // slot selection
        dbnc_en = 1'b0; cyc(2);
        wr(3'd2, 6'd33); wr(3'd6, 6'd32);
        pad_sel[2:0] = 3'd2;
        cyc(1);
        dbnc_en = 1'b1; cyc(3);
        pulse(0, 1, 2, hit);
        chk(hit, 0, "R1 slot 2 rejects short pulse");
        pulse(0, 2, 2, hit);
        chk(hit, 1, "R1 slot 2 accepts full pulse");
        dbnc_en = 1'b0; pad_sel[2:0] = 3'd6; cyc(2);
        dbnc_en = 1'b1; cyc(3);
        pulse(0, 1, 1, hit);
        chk(hit, 1, "R1 slot 6 one-cycle period");

        // reset clears slot codes
        dbnc_en = 1'b0; pad_sel[2:0] = 3'd1; cyc(2);
        wr(3'd1, 6'd63);
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
        dbnc_en = 1'b1; cyc(3);
        pulse(0, 1, 1, hit);
        chk(hit, 1, "R11 slot codes cleared by reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule